// File: doc/BRIEF.md
# Display bus pixel formatter

This block sits between an internal pixel source and a parallel write-only display port of the 8080 kind. Pixels come in one per handshake, as 24-bit RGB888 or as 16-bit RGB565. The block turns each one into the bus words that the display expects, most significant colour first. The bus can be 8 or 16 bits wide, and the display can take 16, 18 or 24 bits per pixel. On a 16-bit bus at 24 bits per pixel, two pixels share three words and no byte is wasted. The words leave on a valid/ready stream that a separate bus-timing engine consumes.

The configuration inputs select the bus width, the pixel depth, the input format, a byte exchange inside each 16-bit word and an exchange of the red and blue channels. They must stay constant while a frame is in flight. A one-cycle frame-start pulse discards any half-finished pixel pair. The input marks the last pixel of a frame, and the block carries that mark onto the final bus word it produces for that pixel. A combination of bus width and depth that the block cannot serve makes it accept and discard the pixel and pulse an error output.

Top module: `disp_pix_fmt`

## Requirements
- R1: After reset, out_valid and cfg_err are 0 and in_ready is 1.
- R2: When cfg_in565=1 the pixel is in_pix[15:11]=R, [10:5]=G, [4:0]=B, in_pix[23:16] is ignored, and each channel is widened to 8 bits by repeating its top bits below it. When cfg_in565=0, in_pix[23:16]=R, [15:8]=G and [7:0]=B.
- R3: With cfg_bus16=0 and cfg_depth=2 (24 bpp), each pixel gives three words carrying R, G and then B in out_word[7:0]. On an 8-bit bus out_word[15:8] is always 0.
- R4: With cfg_bus16=0 and cfg_depth=0 (16 bpp), each pixel gives two words. The first is {R[7:3],G[7:5]} and the second is {G[4:2],B[7:3]}.
- R5: With cfg_bus16=0 and cfg_depth=1 (18 bpp), each pixel gives three words. Each word is a channel's top six bits on out_word[7:2] in the order R, G, B, and out_word[1:0] is 0.
- R6: With cfg_bus16=1 and cfg_depth=0, each pixel gives one word {R[7:3],G[7:2],B[7:3]}.
- R7: With cfg_bus16=1 and cfg_depth=2, pixels pair up into the three words {R0,G0}, {B0,R1} and {G1,B1}, the first-named byte being out_word[15:8].
- R8: In the R7 mode, a frame-last pixel that opens a pair gives {R0,G0} and then {B0,8'h00}.
- R9: out_last is 1 only on the final word produced for a pixel presented with in_last=1. The half-pair word {R0,G0} of a pixel that is not frame-last carries out_last=0.
- R10: cfg_byte_swap=1 exchanges out_word[15:8] and out_word[7:0] of every word on a 16-bit bus. On an 8-bit bus it has no effect.
- R11: cfg_rb_swap=1 exchanges the red and blue channels after R2 and before packing, in every mode.
- R12: While out_valid=1 and out_ready=0, out_word and out_last hold. Under any backpressure, every expected word appears exactly once and in order.
- R13: A frame_start pulse drops a pending half pair, so the next accepted pixel opens a new pair. A pixel accepted in the same cycle as the pulse opens a pair.
- R14: When cfg_depth=3, or when cfg_bus16=1 with cfg_depth=1, an accepted pixel produces no word and cfg_err is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| cfg_bus16 | input | 1 | 1 selects a 16-bit bus, 0 selects an 8-bit bus |
| cfg_depth | input | 2 | 0 = 16 bpp, 1 = 18 bpp, 2 = 24 bpp, 3 = unsupported |
| cfg_in565 | input | 1 | 1 = input pixels are RGB565 |
| cfg_byte_swap | input | 1 | Exchange the bytes of each 16-bit word |
| cfg_rb_swap | input | 1 | Exchange the red and blue channels |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 24 | Input pixel |
| in_last | input | 1 | Input pixel is the last of its frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 16 | Bus word |
| out_last | output | 1 | Final word of the frame |
| cfg_err | output | 1 | Pulse: a pixel was dropped for an unsupported mode |

## Verification
A wrong pair state, such as a stale pending blue byte or a lost frame-start clear, shows up on the next output word as a mismatched byte or a word too many or too few. The bench sees the error no more than one pixel after it arises, because the expected word list is compared word by word. A wrong count of remaining words in the output buffer shows up at the next handshake as a duplicated or skipped word, or as a misplaced out_last flag. Random backpressure across every mode combination makes these states reachable between any two pixels.

// File: rtl/dpf_pkg.sv
`timescale 1ns/1ps
package dpf_pkg;
  localparam int CH_W   = 8;
  localparam int WORD_W = 2 * CH_W;
  localparam int PIX_W  = 3 * CH_W;
  localparam int SLOTS  = 3;
  localparam int CNT_W  = $clog2(SLOTS + 1);

  typedef enum logic [2:0] {
    MD_B8_P16,
    MD_B8_P18,
    MD_B8_P24,
    MD_W16_P16,
    MD_W16_P24,
    MD_BAD
  } mode_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  typedef logic [SLOTS-1:0][WORD_W-1:0] wordset_t;

  function automatic mode_e decode_mode(input logic bus16, input logic [1:0] depth);
    mode_e m;
    m = MD_BAD;
    if (depth != 2'd3) begin
      if (bus16) begin
        if (depth == 2'd0)      m = MD_W16_P16;
        else if (depth == 2'd2) m = MD_W16_P24;
      end else begin
        if (depth == 2'd0)      m = MD_B8_P16;
        else if (depth == 2'd1) m = MD_B8_P18;
        else                    m = MD_B8_P24;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/dpf_normalize.sv
`timescale 1ns/1ps
module dpf_normalize
  import dpf_pkg::*;
(
  input  logic [PIX_W-1:0] pix,
  input  logic             fmt565,
  input  logic             rb_swap,
  output rgb_t             rgb
);
  rgb_t wide;

  always_comb begin
    if (fmt565) begin
      wide.r = {pix[15:11], pix[15:13]};
      wide.g = {pix[10:5],  pix[10:9]};
      wide.b = {pix[4:0],   pix[4:2]};
    end else begin
      wide.r = pix[PIX_W-1:2*CH_W];
      wide.g = pix[2*CH_W-1:CH_W];
      wide.b = pix[CH_W-1:0];
    end
  end

  always_comb begin
    rgb = wide;
    if (rb_swap) begin
      rgb.r = wide.b;
      rgb.b = wide.r;
    end
  end
endmodule

// File: rtl/dpf_packer.sv
`timescale 1ns/1ps
module dpf_packer
  import dpf_pkg::*;
(
  input  mode_e            mode,
  input  rgb_t             px,
  input  logic             px_last,
  input  logic             pend_v,
  input  logic [CH_W-1:0]  pend_b,
  output wordset_t         words,
  output logic [CNT_W-1:0] n_words,
  output logic             words_last,
  output logic             pend_v_nx,
  output logic [CH_W-1:0]  pend_b_nx
);
  localparam logic [CH_W-1:0] ZB = '0;

  always_comb begin
    words      = '0;
    n_words    = '0;
    words_last = px_last;
    pend_v_nx  = 1'b0;
    pend_b_nx  = '0;
    case (mode)
      MD_B8_P24: begin
        words[0] = {ZB, px.r};
        words[1] = {ZB, px.g};
        words[2] = {ZB, px.b};
        n_words  = CNT_W'(3);
      end
      MD_B8_P18: begin
        words[0] = {ZB, px.r[7:2], 2'b00};
        words[1] = {ZB, px.g[7:2], 2'b00};
        words[2] = {ZB, px.b[7:2], 2'b00};
        n_words  = CNT_W'(3);
      end
      MD_B8_P16: begin
        words[0] = {ZB, px.r[7:3], px.g[7:5]};
        words[1] = {ZB, px.g[4:2], px.b[7:3]};
        n_words  = CNT_W'(2);
      end
      MD_W16_P16: begin
        words[0] = {px.r[7:3], px.g[7:2], px.b[7:3]};
        n_words  = CNT_W'(1);
      end
      MD_W16_P24: begin
        if (pend_v) begin
          words[0] = {pend_b, px.r};
          words[1] = {px.g, px.b};
          n_words  = CNT_W'(2);
        end else if (px_last) begin
          words[0] = {px.r, px.g};
          words[1] = {px.b, ZB};
          n_words  = CNT_W'(2);
        end else begin
          words[0]   = {px.r, px.g};
          n_words    = CNT_W'(1);
          words_last = 1'b0;
          pend_v_nx  = 1'b1;
          pend_b_nx  = px.b;
        end
      end
      default: begin
        words_last = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dpf_outq.sv
`timescale 1ns/1ps
module dpf_outq
  import dpf_pkg::*;
#(
  parameter int NSLOT = SLOTS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [NSLOT-1:0][WORD_W-1:0] ld_words,
  input  logic [CNT_W-1:0]             ld_count,
  input  logic                         ld_last,
  input  logic                         swap_en,
  output logic                         ready_load,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [WORD_W-1:0]            out_word,
  output logic                         out_last
);
  logic [NSLOT-1:0][WORD_W-1:0] slot_q, slot_d;
  logic [CNT_W-1:0]             left_q, left_d;
  logic                         last_q, last_d;
  logic                         pop;
  logic                         slot_en;

  assign out_valid  = (left_q != '0);
  assign pop        = out_valid && out_ready;
  assign ready_load = (left_q == '0) || ((left_q == CNT_W'(1)) && out_ready);
  assign slot_en    = load || pop;

  always_comb begin
    left_d = left_q;
    last_d = last_q;
    if (load) begin
      left_d = ld_count;
      last_d = ld_last;
    end else if (pop) begin
      left_d = left_q - CNT_W'(1);
    end
  end

  genvar i;
  generate
    for (i = 0; i < NSLOT; i++) begin : g_slot
      if (i < NSLOT - 1) begin : g_mid
        assign slot_d[i] = load ? ld_words[i] : slot_q[i+1];
      end else begin : g_end
        assign slot_d[i] = load ? ld_words[i] : '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       slot_q[i] <= '0;
        else if (slot_en) slot_q[i] <= slot_d[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      last_q <= 1'b0;
    end else begin
      left_q <= left_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    if (swap_en) out_word = {slot_q[0][CH_W-1:0], slot_q[0][WORD_W-1:CH_W]};
    else         out_word = slot_q[0];
  end

  assign out_last = out_valid && last_q && (left_q == CNT_W'(1));
endmodule

// File: rtl/disp_pix_fmt.sv
`timescale 1ns/1ps
module disp_pix_fmt
  import dpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              cfg_bus16,
  input  logic [1:0]        cfg_depth,
  input  logic              cfg_in565,
  input  logic              cfg_byte_swap,
  input  logic              cfg_rb_swap,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last,
  output logic              cfg_err
);
  logic rst_meta, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  mode_e            mode;
  rgb_t             px;
  wordset_t         pk_words;
  logic [CNT_W-1:0] pk_n;
  logic             pk_last;
  logic             pk_pend_v;
  logic [CH_W-1:0]  pk_pend_b;
  logic             pend_v_q, pend_v_d, pend_eff;
  logic [CH_W-1:0]  pend_b_q, pend_b_d;
  logic             err_d;
  logic             accept, good, load;
  logic             pend_en;

  assign mode     = decode_mode(cfg_bus16, cfg_depth);
  assign good     = (mode != MD_BAD);
  assign accept   = in_valid && in_ready;
  assign load     = accept && good;
  assign pend_eff = pend_v_q && !frame_start;

  dpf_normalize u_norm (
    .pix     (in_pix),
    .fmt565  (cfg_in565),
    .rb_swap (cfg_rb_swap),
    .rgb     (px)
  );

  dpf_packer u_pack (
    .mode       (mode),
    .px         (px),
    .px_last    (in_last),
    .pend_v     (pend_eff),
    .pend_b     (pend_b_q),
    .words      (pk_words),
    .n_words    (pk_n),
    .words_last (pk_last),
    .pend_v_nx  (pk_pend_v),
    .pend_b_nx  (pk_pend_b)
  );

  dpf_outq #(.NSLOT(SLOTS)) u_q (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load       (load),
    .ld_words   (pk_words),
    .ld_count   (pk_n),
    .ld_last    (pk_last),
    .swap_en    (cfg_byte_swap && cfg_bus16),
    .ready_load (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_word   (out_word),
    .out_last   (out_last)
  );

  always_comb begin
    pend_v_d = pend_eff;
    pend_b_d = pend_b_q;
    if (load) begin
      pend_v_d = pk_pend_v;
      pend_b_d = pk_pend_b;
    end
  end

  assign pend_en = load || frame_start;
  assign err_d   = accept && !good;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pend_v_q <= 1'b0;
      pend_b_q <= '0;
    end else if (pend_en) begin
      pend_v_q <= pend_v_d;
      pend_b_q <= pend_b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) cfg_err <= 1'b0;
    else             cfg_err <= err_d;
  end
endmodule

// File: rtl/disp_pix_fmt_chk.sv
`timescale 1ns/1ps
module disp_pix_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_bus16,
  input logic [1:0]  cfg_depth,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_word,
  input logic        out_last,
  input logic        cfg_err
);
  logic combo_bad;
  assign combo_bad = (cfg_depth == 2'd3) || (cfg_bus16 && cfg_depth == 2'd1);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last));

  assert_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cfg_bus16 |-> out_word[15:8] == 8'h00);

  assert_pad18_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cfg_bus16 && cfg_depth == 2'd1 |-> out_word[1:0] == 2'b00);

  assert_err_cause_R14: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(in_valid && in_ready && combo_bad));

  assert_err_follow_R14: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && combo_bad |=> cfg_err);

  assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind disp_pix_fmt disp_pix_fmt_chk u_chk (.*);

// File: tb/disp_pix_fmt_test.sv
`timescale 1ns/1ps
module disp_pix_fmt_test;
  logic        clk;
  logic        rst_n;
  logic        frame_start;
  logic        cfg_bus16;
  logic [1:0]  cfg_depth;
  logic        cfg_in565, cfg_byte_swap, cfg_rb_swap;
  logic        in_valid, in_ready, in_last;
  logic [23:0] in_pix;
  logic        out_valid, out_ready, out_last;
  logic [15:0] out_word;
  logic        cfg_err;

  disp_pix_fmt uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_bus16(cfg_bus16), .cfg_depth(cfg_depth), .cfg_in565(cfg_in565),
    .cfg_byte_swap(cfg_byte_swap), .cfg_rb_swap(cfg_rb_swap),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_last(out_last), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int          total = 0;
  int          bad = 0;
  logic [16:0] exp_q[$];
  logic        m_pend;
  logic [7:0]  m_pb;
  logic [15:0] lfsr = 16'hACE1;
  logic        acc;
  logic        err_exp = 1'b0;
  int          err_seen;
  int          bp_mode;

  function automatic string tag_of();
    if (cfg_depth == 2'd3 || (cfg_bus16 && cfg_depth == 2'd1)) return "R14";
    if (cfg_bus16) return (cfg_depth == 2'd0) ? "R6" : "R7";
    if (cfg_depth == 2'd0) return "R4";
    if (cfg_depth == 2'd1) return "R5";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic push_word(input logic [15:0] w, input logic l);
    logic [15:0] x;
    x = (cfg_bus16 && cfg_byte_swap) ? {w[7:0], w[15:8]} : w;  // R10
    exp_q.push_back({l, x});
  endtask

  // expected words from R2..R11
  task automatic model_pixel(input logic [23:0] p, input logic lst);
    int r, g, b, t;
    if (cfg_in565) begin
      r = p[15:11]; g = p[10:5]; b = p[4:0];
      r = r * 8 + r / 4; g = g * 4 + g / 16; b = b * 8 + b / 4;
    end else begin
      r = p[23:16]; g = p[15:8]; b = p[7:0];
    end
    if (cfg_rb_swap) begin t = r; r = b; b = t; end  // R11
    if (cfg_depth == 2'd3 || (cfg_bus16 && cfg_depth == 2'd1)) return;
    if (!cfg_bus16) begin
      if (cfg_depth == 2'd2) begin
        push_word(16'(r), 1'b0); push_word(16'(g), 1'b0); push_word(16'(b), lst);
      end else if (cfg_depth == 2'd1) begin
        push_word(16'((r / 4) * 4), 1'b0); push_word(16'((g / 4) * 4), 1'b0);
        push_word(16'((b / 4) * 4), lst);
      end else begin
        push_word(16'((r / 8) * 8 + g / 32), 1'b0);
        push_word(16'(((g / 4) % 8) * 32 + b / 8), lst);
      end
    end else if (cfg_depth == 2'd0) begin
      push_word(16'((r / 8) * 2048 + (g / 4) * 32 + b / 8), lst);
    end else begin
      if (m_pend) begin
        push_word(16'(m_pb * 256 + r), 1'b0);
        push_word(16'(g * 256 + b), lst);
        m_pend = 1'b0;
      end else if (lst) begin
        push_word(16'(r * 256 + g), 1'b0);
        push_word(16'(b * 256), 1'b1);  // R8
      end else begin
        push_word(16'(r * 256 + g), 1'b0);  // R9: half pair not last
        m_pend = 1'b1;
        m_pb = 8'(b);
      end
    end
  endtask

  task automatic cycle();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0] | lfsr[3];
      default: out_ready = lfsr[1];
    endcase
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check({tag_of(), " R12 extra word"}, {15'd0, out_last, out_word}, 32'hFFFFFFFF);
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        check({tag_of(), " R2 R9 R10 R11 R12 R13 word"}, {15'd0, out_last, out_word}, {15'd0, e});
      end
    end
    if (cfg_err || err_exp) check("R14 err pulse", {31'd0, cfg_err}, {31'd0, err_exp});
    if (cfg_err) err_seen++;
    acc = in_valid && in_ready;
    if (frame_start) m_pend = 1'b0;  // R13
    err_exp = acc && (cfg_depth == 2'd3 || (cfg_bus16 && cfg_depth == 2'd1));
    if (acc) model_pixel(in_pix, in_last);
    @(negedge clk);
  endtask

  task automatic send_pixel(input logic fs, input logic lst);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    in_pix      = {lfsr, lfsr[7:0] ^ lfsr[15:8] ^ 8'h5A};
    in_valid    = 1'b1;
    in_last     = lst;
    frame_start = fs;
    acc = 1'b0;
    for (int k = 0; k < 50 && !acc; k++) begin
      cycle();
      frame_start = 1'b0;
    end
    if (!acc) check("R12 input stalled", 32'd0, 32'd1);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    for (int k = 0; k < 100 && (exp_q.size() != 0 || out_valid || err_exp); k++) cycle();
    check({tag_of(), " R12 drained"}, exp_q.size(), 0);
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; cfg_bus16 = 1'b0; cfg_depth = 2'd0;
    cfg_in565 = 1'b0; cfg_byte_swap = 1'b0; cfg_rb_swap = 1'b0;
    in_valid = 1'b0; in_pix = '0; in_last = 1'b0; out_ready = 1'b0;
    m_pend = 1'b0; m_pb = '0; bp_mode = 0; acc = 1'b0; err_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 cfg_err", {31'd0, cfg_err}, 32'd0);

    for (int cfg = 0; cfg < 64; cfg++) begin
      cfg_bus16     = cfg[0];
      cfg_depth     = cfg[2:1];
      cfg_in565     = cfg[3];
      cfg_byte_swap = cfg[4];
      cfg_rb_swap   = cfg[5];
      bp_mode       = cfg % 3;
      err_seen      = 0;
      for (int n = 1; n <= 5; n++) begin
        for (int i = 0; i < n; i++) send_pixel(i == 0, i == n - 1);  // R8 odd, R9
        if (n == 3) begin
          for (int i = 0; i < 3; i++) send_pixel(i == 0, 1'b0);  // R13 abandoned
        end
      end
      drain();
      if (tag_of() == "R14") check("R14 dropped pixels flagged", err_seen, 18);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule